// File: doc/BRIEF.md
# Programmable Asynchronous Character Transmitter

This block turns one parallel byte into one asynchronous serial character. The character is made of a low start bit, then 5 to 8 data bits sent least significant bit first, then an optional parity bit, then a high stop interval. Bit timing comes from a 16-bit divisor applied to the input clock. The divisor produces a tick at 16 times the bit rate, and one bit time is 16 ticks. The stop interval can last one, one and a half or two bit times. Parity can be even, odd, held at a fixed level, or left out.

A byte is handed over with a valid/ready handshake, and the transmitter takes a new byte only while it is idle. At the moment of acceptance it captures the byte, the divisor and every framing setting, so later changes on those inputs cannot disturb a character that is already on the line. A break input pulls the serial output low for as long as it is asserted. The internal sequence keeps running underneath it. When the stop interval ends, a one-cycle done pulse marks the end of the character and ready goes high again.

Top module: `async_char_tx`

## Requirements
- R1: After reset, txd is 1, in_ready is 1, busy is 0 and done is 0.
- R2: A character starts with one start bit at level 0. Every bit lasts 16*D clock cycles, where D is the captured divisor and a divisor of 0 acts as 1. The start bit begins in the cycle right after the accepting clock edge.
- R3: The data bits follow the start bit, least significant bit first. Their number is word_len+5, with word_len 0 giving 5 bits and word_len 3 giving 8 bits.
- R4: With par_en=0 no parity bit is sent. With par_en=1 and par_stick=0 a parity bit follows the data. For par_even=1 it makes the count of ones in data plus parity even, and for par_even=0 it makes that count odd. With par_stick=1 the parity bit is the constant NOT par_even.
- R5: The stop interval is at level 1. It lasts 16 ticks when stop_long=0. When stop_long=1 it lasts 24 ticks with a 5-bit word and 32 ticks with a 6 to 8-bit word.
- R6: in_ready is 1 exactly while the transmitter is idle, and busy is its complement. A byte is taken on a clock edge where in_valid and in_ready are both 1. in_valid while busy has no effect.
- R7: The data, divisor and framing settings are captured when the byte is accepted. Changes on those inputs during a character do not alter that character.
- R8: In the cycle after the stop interval ends, done is 1 for exactly one cycle, in_ready returns to 1 and busy returns to 0.
- R9: While brk is 1, txd is 0. Asserting brk does not change when or how the rest of the character is sent.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| divisor | input | 16 | Clock divisor for the 16x tick, 1 to 65535 (0 acts as 1) |
| word_len | input | 2 | Data bits minus 5 |
| stop_long | input | 1 | 0: one stop bit; 1: 1.5 bits (5-bit word) or 2 bits |
| par_en | input | 1 | Parity bit present |
| par_even | input | 1 | Even parity select (fixed level 0 when sticky) |
| par_stick | input | 1 | Parity held at a fixed level |
| brk | input | 1 | Forces txd low |
| in_valid | input | 1 | Byte offered |
| in_data | input | 8 | Byte to send |
| in_ready | output | 1 | Idle and able to accept |
| busy | output | 1 | Character in progress |
| done | output | 1 | One-cycle pulse at the end of a character |
| txd | output | 1 | Serial line output, idles high |

## Verification
The hardest cases to reach from the ports are the ones where inputs change while a character is on the line. The stimulus covers three of them. In one, every setting is turned over right after the accepting edge. In another, in_valid is held high straight through a character while in_data changes. In the third, brk is pulsed in the middle of the data bits. A behavioural model builds the expected waveform cycle by cycle from the settings captured at acceptance, so any late sampling or disturbed sequencing shows up as a mismatch. The 1.5-bit stop is run with a 5-bit word and sticky parity, and it is also run at a divisor large enough that a miscounted half bit shows.

// File: rtl/async_tx_pkg.sv
package async_tx_pkg;

  localparam int unsigned TICKS_PER_BIT = 16;

  typedef enum logic [2:0] {
    S_IDLE,
    S_START,
    S_DATA,
    S_PAR,
    S_STOP
  } tx_state_t;

  // parity over the active low bits of the word
  function automatic logic calc_parity(input logic [7:0] d,
                                       input logic [1:0] wl,
                                       input logic       even_sel,
                                       input logic       stick);
    logic [7:0] m;
    m = d & (8'hFF >> (3'd3 - {1'b0, wl}));
    if (stick) return ~even_sel;
    return even_sel ? ^m : ~^m;
  endfunction

endpackage

// File: rtl/tx_tick_gen.sv
module tx_tick_gen #(
  parameter int unsigned DIV_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [DIV_W-1:0] div_in,
  input  logic             run,
  output logic             tick
);

  logic [DIV_W-1:0] div_q, div_d;
  logic [DIV_W-1:0] cnt_q, cnt_d;

  assign tick = run && (cnt_q == div_q - DIV_W'(1));

  always_comb begin
    div_d = div_q;
    if (load) div_d = (div_in == '0) ? DIV_W'(1) : div_in;
    if (!run || tick) cnt_d = '0;
    else              cnt_d = cnt_q + DIV_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_q <= DIV_W'(1);
      cnt_q <= '0;
    end else begin
      div_q <= div_d;
      cnt_q <= cnt_d;
    end
  end

  // R2: with a divisor above one, ticks never come back to back
  p_tick_spacing_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && div_q != DIV_W'(1) && run) |=> !tick);

endmodule

// File: rtl/tx_frame_seq.sv
module tx_frame_seq
  import async_tx_pkg::*;
#(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              in_valid,
  input  logic [DATA_W-1:0] in_data,
  input  logic [1:0]        word_len,
  input  logic              stop_long,
  input  logic              par_en,
  input  logic              par_even,
  input  logic              par_stick,
  output logic              in_ready,
  output logic              busy,
  output logic              done,
  output logic              line
);

  localparam int unsigned TCNT_W = $clog2(2 * TICKS_PER_BIT);
  localparam int unsigned BIDX_W = $clog2(DATA_W);
  localparam logic [TCNT_W-1:0] BIT_LAST  = TCNT_W'(TICKS_PER_BIT - 1);
  localparam logic [TCNT_W-1:0] HALF_LAST = TCNT_W'(TICKS_PER_BIT + TICKS_PER_BIT/2 - 1);
  localparam logic [TCNT_W-1:0] TWO_LAST  = TCNT_W'(2 * TICKS_PER_BIT - 1);

  tx_state_t         state_q, state_d;
  logic [TCNT_W-1:0] tcnt_q, tcnt_d;
  logic [TCNT_W-1:0] stop_last_q, stop_last_d;
  logic [BIDX_W-1:0] bidx_q, bidx_d;
  logic [BIDX_W-1:0] blast_q, blast_d;
  logic [DATA_W-1:0] shreg_q, shreg_d;
  logic              par_q, par_d;
  logic              pen_q, pen_d;
  logic              done_q, done_d;
  logic              accept, phase_end;

  assign in_ready = (state_q == S_IDLE);
  assign busy     = ~in_ready;
  assign done     = done_q;
  assign accept   = in_valid && in_ready;
  assign phase_end = tick &&
    (tcnt_q == ((state_q == S_STOP) ? stop_last_q : BIT_LAST));

  always_comb begin
    state_d     = state_q;
    tcnt_d      = tcnt_q;
    stop_last_d = stop_last_q;
    bidx_d      = bidx_q;
    blast_d     = blast_q;
    shreg_d     = shreg_q;
    par_d       = par_q;
    pen_d       = pen_q;
    done_d      = 1'b0;
    if (accept) begin
      state_d     = S_START;
      tcnt_d      = '0;
      bidx_d      = '0;
      shreg_d     = in_data;
      blast_d     = BIDX_W'(word_len) + BIDX_W'(4);
      par_d       = calc_parity(8'(in_data), word_len, par_even, par_stick);
      pen_d       = par_en;
      stop_last_d = !stop_long ? BIT_LAST :
                    (word_len == 2'd0) ? HALF_LAST : TWO_LAST;
    end else if (tick) begin
      tcnt_d = phase_end ? '0 : tcnt_q + TCNT_W'(1);
      if (phase_end) begin
        unique case (state_q)
          S_START: state_d = S_DATA;
          S_DATA: begin
            shreg_d = shreg_q >> 1;
            if (bidx_q == blast_q) state_d = pen_q ? S_PAR : S_STOP;
            else                   bidx_d  = bidx_q + BIDX_W'(1);
          end
          S_PAR:  state_d = S_STOP;
          S_STOP: begin
            state_d = S_IDLE;
            done_d  = 1'b1;
          end
          default: state_d = S_IDLE;
        endcase
      end
    end
  end

  always_comb begin
    unique case (state_q)
      S_START: line = 1'b0;
      S_DATA:  line = shreg_q[0];
      S_PAR:   line = par_q;
      default: line = 1'b1;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q     <= S_IDLE;
      tcnt_q      <= '0;
      stop_last_q <= BIT_LAST;
      bidx_q      <= '0;
      blast_q     <= '0;
      shreg_q     <= '0;
      par_q       <= 1'b0;
      pen_q       <= 1'b0;
      done_q      <= 1'b0;
    end else begin
      state_q     <= state_d;
      tcnt_q      <= tcnt_d;
      stop_last_q <= stop_last_d;
      bidx_q      <= bidx_d;
      blast_q     <= blast_d;
      shreg_q     <= shreg_d;
      par_q       <= par_d;
      pen_q       <= pen_d;
      done_q      <= done_d;
    end
  end

  // R6: an accepted byte makes the block busy on the next cycle
  p_accept_busy_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> busy);

  // R6: an idle block with nothing offered stays idle
  p_idle_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (in_ready && !in_valid) |=> in_ready);

  // R8: done lasts exactly one cycle
  p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R8: done only ever appears together with ready
  p_done_ready_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> in_ready);

endmodule

// File: rtl/async_char_tx.sv
module async_char_tx #(
  parameter int unsigned DIV_W  = 16,
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DIV_W-1:0]  divisor,
  input  logic [1:0]        word_len,
  input  logic              stop_long,
  input  logic              par_en,
  input  logic              par_even,
  input  logic              par_stick,
  input  logic              brk,
  input  logic              in_valid,
  input  logic [DATA_W-1:0] in_data,
  output logic              in_ready,
  output logic              busy,
  output logic              done,
  output logic              txd
);

  logic tick;
  logic line;

  tx_tick_gen #(.DIV_W(DIV_W)) u_tick (
    .clk    (clk),
    .rst_n  (rst_n),
    .load   (in_valid && in_ready),
    .div_in (divisor),
    .run    (busy),
    .tick   (tick)
  );

  tx_frame_seq #(.DATA_W(DATA_W)) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick      (tick),
    .in_valid  (in_valid),
    .in_data   (in_data),
    .word_len  (word_len),
    .stop_long (stop_long),
    .par_en    (par_en),
    .par_even  (par_even),
    .par_stick (par_stick),
    .in_ready  (in_ready),
    .busy      (busy),
    .done      (done),
    .line      (line)
  );

  assign txd = line & ~brk;

  // R9: break holds the line low
  p_brk_low_r9: assert property (@(posedge clk) disable iff (!rst_n)
    brk |-> !txd);

  // R2: the first cycle of a character is the low start bit
  p_start_low_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(busy) && !brk) |-> !txd);

endmodule

// File: tb/async_char_tx_test.sv
`timescale 1ns/1ps
module async_char_tx_test;

  localparam int LIMIT = 150000;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [15:0] divisor;
  logic [1:0]  word_len;
  logic        stop_long, par_en, par_even, par_stick, brk, in_valid;
  logic [7:0]  in_data;
  logic        in_ready, busy, done, txd;

  always #4 clk = ~clk;

  async_char_tx uut (
    .clk(clk), .rst_n(rst_n), .divisor(divisor), .word_len(word_len),
    .stop_long(stop_long), .par_en(par_en), .par_even(par_even),
    .par_stick(par_stick), .brk(brk), .in_valid(in_valid),
    .in_data(in_data), .in_ready(in_ready), .busy(busy), .done(done),
    .txd(txd)
  );

  int checks = 0;
  int errors = 0;
  int cyc    = 0;
  int scr_tag = 0;   // nonzero: tag this frame as R7

  logic exq[$];
  int   tgq[$];
  logic exp_done = 1'b0;

  task automatic push_bits(input logic lvl, input int tag, input int n);
    for (int k = 0; k < n; k++) begin
      exq.push_back(lvl);
      tgq.push_back(scr_tag != 0 ? scr_tag : tag);
    end
  endtask

  // behavioural frame from the settings seen at acceptance
  task automatic push_frame();
    int d, n, ones, stop_t;
    logic p;
    d = (divisor == 16'd0) ? 1 : int'(divisor);
    n = int'(word_len) + 5;
    push_bits(1'b0, 2, 16 * d);
    ones = 0;
    for (int i = 0; i < n; i++) begin
      push_bits(in_data[i], 3, 16 * d);
      ones += int'(in_data[i]);
    end
    if (par_en) begin
      if (par_stick) p = ~par_even;
      else if (par_even) p = (ones % 2 == 1);
      else p = (ones % 2 == 0);
      push_bits(p, 4, 16 * d);
    end
    stop_t = !stop_long ? 16 : (n == 5 ? 24 : 32);
    push_bits(1'b1, 5, stop_t * d);
  endtask

  task automatic report(input string what, input int tag, input logic act, input logic exp);
    errors++;
    $display("FAIL R%0d %s actual=%0b expected=%0b at cycle %0d", tag, what, act, exp, cyc);
  endtask

  always @(negedge clk) begin
    logic et, eb, er;
    int   tg;
    cyc++;
    if (cyc > LIMIT) begin
      errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
    checks++;
    if (exq.size() > 0) begin
      et = exq[0] & ~brk; tg = brk ? 9 : tgq[0]; eb = 1'b1; er = 1'b0;
    end else begin
      et = ~brk; tg = brk ? 9 : 1; eb = 1'b0; er = 1'b1;   // R1 idle level
    end
    if (txd !== et)       report("txd", tg, txd, et);
    if (busy !== eb)      report("busy", 6, busy, eb);
    if (in_ready !== er)  report("in_ready", 6, in_ready, er);
    if (done !== exp_done) report("done", 8, done, exp_done);
    exp_done = 1'b0;
    if (rst_n) begin
      if (exq.size() > 0) begin
        void'(exq.pop_front());
        void'(tgq.pop_front());
        if (exq.size() == 0) exp_done = 1'b1;
      end else if (in_valid) begin
        push_frame();
      end
    end
  end

  task automatic wait_idle();
    do @(negedge clk); while (exq.size() != 0);
    repeat (3) @(negedge clk);
  endtask

  task automatic send(input logic [7:0] d, input logic [1:0] wl, input logic sl,
                      input logic pen, input logic pev, input logic pst,
                      input logic [15:0] dv, input bit scramble);
    @(posedge clk); #1;
    in_data = d; word_len = wl; stop_long = sl; par_en = pen;
    par_even = pev; par_stick = pst; divisor = dv;
    scr_tag = scramble ? 7 : 0;
    in_valid = 1'b1;
    do @(negedge clk); while (!(in_ready && exq.size() == 0));
    @(posedge clk); #1;
    in_valid = 1'b0;
    scr_tag = 0;
    if (scramble) begin
      in_data = ~d; word_len = ~wl; stop_long = ~sl; par_en = ~pen;
      par_even = ~pev; par_stick = ~pst; divisor = dv + 16'd5;
    end
  endtask

  initial begin
    rst_n = 1'b0; divisor = 16'd1; word_len = 2'd3; stop_long = 1'b0;
    par_en = 1'b0; par_even = 1'b0; par_stick = 1'b0; brk = 1'b0;
    in_valid = 1'b0; in_data = 8'h00;
    repeat (3) @(posedge clk);   // R1: reset state compared every cycle
    #1 rst_n = 1'b1;
    repeat (3) @(posedge clk);

    // R2 R3 R5: 8-bit, no parity, one stop
    send(8'hA5, 2'd3, 1'b0, 1'b0, 1'b0, 1'b0, 16'd1, 1'b0); wait_idle();
    // R4: even parity, divisor 2
    send(8'h3C, 2'd3, 1'b0, 1'b1, 1'b1, 1'b0, 16'd2, 1'b0); wait_idle();
    // R4 R5: odd parity, two stop bits
    send(8'h3D, 2'd3, 1'b1, 1'b1, 1'b0, 1'b0, 16'd1, 1'b0); wait_idle();
    // R4 R5: 5-bit, sticky odd (1), 1.5 stop
    send(8'hF5, 2'd0, 1'b1, 1'b1, 1'b0, 1'b1, 16'd1, 1'b0); wait_idle();
    // R4 R5: 6-bit, sticky even (0), two stop, divisor 3
    send(8'h0B, 2'd1, 1'b1, 1'b1, 1'b1, 1'b1, 16'd3, 1'b0); wait_idle();
    // R3 R4: 7-bit even parity
    send(8'h7F, 2'd2, 1'b0, 1'b1, 1'b1, 1'b0, 16'd1, 1'b0); wait_idle();
    // R2: divisor 0 acts as 1
    send(8'h81, 2'd3, 1'b0, 1'b0, 1'b0, 1'b0, 16'd0, 1'b0); wait_idle();
    // R7: all inputs change after acceptance
    send(8'hC3, 2'd3, 1'b0, 1'b1, 1'b1, 1'b0, 16'd2, 1'b1); wait_idle();

    // R6: valid held through a character, data changed while busy
    @(posedge clk); #1;
    divisor = 16'd1; word_len = 2'd3; stop_long = 1'b0; par_en = 1'b0;
    in_data = 8'h5A; in_valid = 1'b1;
    repeat (20) @(posedge clk); #1;
    in_data = 8'hE7;
    do @(negedge clk); while (!exp_done);
    @(posedge clk); #1;
    repeat (5) @(posedge clk); #1;
    in_valid = 1'b0;
    wait_idle();

    // R9: break in the middle of the data bits and while idle
    send(8'h96, 2'd3, 1'b0, 1'b1, 1'b0, 1'b0, 16'd1, 1'b0);
    repeat (40) @(posedge clk); #1;
    brk = 1'b1;
    repeat (30) @(posedge clk); #1;
    brk = 1'b0;
    wait_idle();
    @(posedge clk); #1 brk = 1'b1;
    repeat (4) @(posedge clk); #1 brk = 1'b0;
    repeat (2) @(posedge clk);

    // R5: 1.5 stop at a large divisor
    send(8'h0E, 2'd0, 1'b1, 1'b0, 1'b0, 1'b0, 16'd20, 1'b0); wait_idle();

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule